// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits between a small request buffer and the command lane of a DRAM channel. Requests enter through a valid/ready port. Each request carries a bank, a row, a column and a read/write flag, and is stamped with its arrival order. The block tracks, for every bank, whether a row is open, which row that is, and a busy timer. Once per cycle it turns one buffered request into the next command that request needs: activate, precharge, read or write. It then offers that command on a single-issue valid/ready command port.

Two configuration pins set the behaviour. The first selects the policy. Under the default policy, a column command that hits an already open row beats any row command, and age decides within each class. Under the oldest-first policy, only the oldest buffered request may advance. The second pin selects row management. In open-row mode a row stays open until a conflicting request needs the bank. In closed-row mode a bank is precharged after its accesses, unless a buffered request still targets its open row.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low only while every buffer slot is occupied. Once `cmd_valid` rises, the command fields stay frozen until the edge where `cmd_ready` is high. The command takes effect on the bank state at that edge.

Top module: `dram_row_sched`

## Requirements
- R1: A request is stored on an edge with `req_valid` and `req_ready` high; `req_ready` is low exactly when all NUM_ENTRIES slots hold requests, and a request offered while it is low is dropped without any effect.
- R2: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_type`, `cmd_bank`, `cmd_row` and `cmd_col` hold their values on the next cycle.
- R3: `cmd_type` encodes activate as 0, precharge as 1, read as 2 and write as 3. A request to a closed bank gets activate (carrying its row) and then its column command. A request to an open bank with another row gets precharge, activate and then the column command. The column command is read or write according to `req_write`.
- R4: Under the default policy, a ready column command that hits the open row of its bank is issued before any ready row command, even one from an older request.
- R5: Within the same class, the request that arrived earlier wins; equal stamps go to the lower buffer slot.
- R6: In closed-row mode, a bank is precharged once no buffered request targets its open row. A buffered request that still hits the open row is served with its column command alone, with no new activate.
- R7: With `cfg_oldest_first` high, only the oldest buffered request advances, whether or not other requests hit an open row.
- R8: A column command follows the activate of its bank by at least T_RCD cycles, an activate follows a precharge of its bank by at least T_RP cycles, and no command goes to a bank with a row already open or without the requested row open. With no competing work, both gaps are exactly T_RCD and T_RP.
- R9: After reset `cmd_valid` is low, `req_ready` is high and every bank is closed.
- R10: A slot is released only on the edge where its column command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_closed_row | input | 1 | 1 selects closed-row management, 0 open-row |
| cfg_oldest_first | input | 1 | 1 selects strict oldest-first, 0 row-hit-first |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A buffer slot is free |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 write, 0 read |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command lane accepts |
| cmd_type | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate (open row for precharge) |
| cmd_col | output | COL_W | Column for read/write, 0 otherwise |

## Verification
A corrupted open-row register or open flag shows up within a single command. The block either issues a column command with no activate before it, or issues a spurious precharge and activate pair. A timer that loads the wrong value shifts the gap between a precharge, activate and column trio by a cycle, and that gap is measured on the command port. A wrong age or class comparison reverses the order of the column commands for a mixed hit and conflict burst. A slot that is freed too early or too late shows at `req_ready` on the cycle after the activate of a full buffer.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } dcmd_e;

  function automatic logic cmd_is_col(dcmd_e c);
    return c[1];
  endfunction
endpackage

// File: rtl/req_buffer.sv
module req_buffer #(
  parameter int NUM_ENTRIES = 8,
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [COL_W-1:0]  enq_col,
  input  logic              enq_wr,
  input  logic              free_en,
  input  logic [IDX_W-1:0]  free_idx,
  output logic [NUM_ENTRIES-1:0] ent_vld,
  output logic [BANK_W-1:0] ent_bank [NUM_ENTRIES],
  output logic [ROW_W-1:0]  ent_row  [NUM_ENTRIES],
  output logic [COL_W-1:0]  ent_col  [NUM_ENTRIES],
  output logic [NUM_ENTRIES-1:0] ent_wr,
  output logic [AGE_W-1:0]  ent_age  [NUM_ENTRIES]
);
  logic [AGE_W-1:0] arrival_q;
  logic [IDX_W-1:0] slot;
  logic             slot_found;

  // lowest free slot
  always_comb begin
    slot       = '0;
    slot_found = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        slot       = IDX_W'(i);
        slot_found = 1'b1;
      end
    end
  end

  assign enq_ready = slot_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld   <= '0;
      arrival_q <= '0;
    end else begin
      if (free_en) ent_vld[free_idx] <= 1'b0;
      if (enq_valid && slot_found) begin
        ent_vld[slot]  <= 1'b1;
        ent_bank[slot] <= enq_bank;
        ent_row[slot]  <= enq_row;
        ent_col[slot]  <= enq_col;
        ent_wr[slot]   <= enq_wr;
        ent_age[slot]  <= arrival_q;
        arrival_q      <= arrival_q + 1'b1;
      end
    end
  end

  // R10: only a live slot can be released
  a_r10_free_live: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> ent_vld[free_idx]);
endmodule

// File: rtl/bank_state.sv
module bank_state
  import dram_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 2,
  localparam int T_MAX    = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int TMR_W    = (T_MAX < 2) ? 1 : $clog2(T_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  dcmd_e             issue_cmd,
  input  logic [BANK_W-1:0] issue_bank,
  input  logic [ROW_W-1:0]  issue_row,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [ROW_W-1:0]  bank_row [NUM_BANKS],
  output logic [NUM_BANKS-1:0] bank_rdy
);
  localparam logic [TMR_W-1:0] LOAD_RCD = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] LOAD_RP  = TMR_W'(T_RP - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TMR_W-1:0] tmr_q;
    logic             hit_me;

    assign hit_me      = issue_en && (issue_bank == BANK_W'(b));
    assign bank_rdy[b] = (tmr_q == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        bank_row[b]  <= '0;
        tmr_q        <= '0;
      end else if (hit_me && issue_cmd == CMD_ACT) begin
        bank_open[b] <= 1'b1;
        bank_row[b]  <= issue_row;
        tmr_q        <= LOAD_RCD;
      end else if (hit_me && issue_cmd == CMD_PRE) begin
        bank_open[b] <= 1'b0;
        tmr_q        <= LOAD_RP;
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end

    // R8: activate only to an idle, closed bank
    a_r8_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_me && issue_cmd == CMD_ACT) |-> (!bank_open[b] && tmr_q == '0));
    // R8: precharge only to an idle, open bank
    a_r8_pre_open: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_me && issue_cmd == CMD_PRE) |-> (bank_open[b] && tmr_q == '0));
    // R8: column only to the open requested row after the delay
    a_r8_col_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_me && cmd_is_col(issue_cmd)) |->
        (bank_open[b] && tmr_q == '0 && bank_row[b] == issue_row));
  end
endmodule

// File: rtl/cmd_picker.sv
module cmd_picker
  import dram_sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              cfg_closed_row,
  input  logic              cfg_oldest_first,
  input  logic [NUM_ENTRIES-1:0] ent_vld,
  input  logic [BANK_W-1:0] ent_bank [NUM_ENTRIES],
  input  logic [ROW_W-1:0]  ent_row  [NUM_ENTRIES],
  input  logic [COL_W-1:0]  ent_col  [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] ent_wr,
  input  logic [AGE_W-1:0]  ent_age  [NUM_ENTRIES],
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [ROW_W-1:0]  bank_row [NUM_BANKS],
  input  logic [NUM_BANKS-1:0] bank_rdy,
  output logic              pick_vld,
  output dcmd_e             pick_cmd,
  output logic [BANK_W-1:0] pick_bank,
  output logic [ROW_W-1:0]  pick_row,
  output logic [COL_W-1:0]  pick_col,
  output logic              pick_from_req,
  output logic [IDX_W-1:0]  pick_idx,
  output logic              col_rdy_any
);
  logic [NUM_ENTRIES-1:0] hit, erdy;
  dcmd_e                  ecmd [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   bank_hit;
  logic                   fr_found, old_found, close_found, req_pick;
  logic [IDX_W-1:0]       fr_best, old_best, sel;
  logic [BANK_W-1:0]      close_bank;

  // wrap-safe arrival comparison
  function automatic logic older(logic [AGE_W-1:0] a, logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  // per-entry next command
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hit[i]  = ent_vld[i] && bank_open[ent_bank[i]] &&
                (bank_row[ent_bank[i]] == ent_row[i]);
      erdy[i] = ent_vld[i] && bank_rdy[ent_bank[i]];
      if (hit[i])                      ecmd[i] = ent_wr[i] ? CMD_WR : CMD_RD;
      else if (bank_open[ent_bank[i]]) ecmd[i] = CMD_PRE;
      else                             ecmd[i] = CMD_ACT;
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_hit[b] = 1'b0;
      for (int i = 0; i < NUM_ENTRIES; i++)
        if (hit[i] && ent_bank[i] == BANK_W'(b)) bank_hit[b] = 1'b1;
    end
  end

  assign col_rdy_any = |(hit & erdy);

  // row-hit-first: class, then age, then lower slot
  always_comb begin
    fr_found = 1'b0;
    fr_best  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (erdy[i]) begin
        if (!fr_found ||
            (cmd_is_col(ecmd[i]) && !cmd_is_col(ecmd[fr_best])) ||
            ((cmd_is_col(ecmd[i]) == cmd_is_col(ecmd[fr_best])) &&
             older(ent_age[i], ent_age[fr_best]))) begin
          fr_found = 1'b1;
          fr_best  = IDX_W'(i);
        end
      end
    end
  end

  // oldest-first: the single oldest live request
  always_comb begin
    old_found = 1'b0;
    old_best  = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (ent_vld[i] && (!old_found || older(ent_age[i], ent_age[old_best]))) begin
        old_found = 1'b1;
        old_best  = IDX_W'(i);
      end
    end
  end

  // closed-row cleanup: lowest idle open bank with no pending hit
  always_comb begin
    close_found = 1'b0;
    close_bank  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (cfg_closed_row && bank_open[b] && bank_rdy[b] && !bank_hit[b]) begin
        close_found = 1'b1;
        close_bank  = BANK_W'(b);
      end
    end
  end

  always_comb begin
    if (cfg_oldest_first) begin
      req_pick = old_found && erdy[old_best];
      sel      = old_best;
    end else begin
      req_pick = fr_found;
      sel      = fr_best;
    end
    pick_idx      = sel;
    pick_from_req = req_pick;
    pick_vld      = req_pick || close_found;
    if (req_pick) begin
      pick_cmd  = ecmd[sel];
      pick_bank = ent_bank[sel];
      pick_row  = (ecmd[sel] == CMD_PRE) ? bank_row[ent_bank[sel]] : ent_row[sel];
      pick_col  = cmd_is_col(ecmd[sel]) ? ent_col[sel] : '0;
    end else begin
      pick_cmd  = CMD_PRE;
      pick_bank = close_bank;
      pick_row  = bank_row[close_bank];
      pick_col  = '0;
    end
  end
endmodule

// File: rtl/dram_row_sched.sv
module dram_row_sched
  import dram_sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 12,
  parameter int T_RCD       = 3,
  parameter int T_RP        = 2,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_closed_row,
  input  logic              cfg_oldest_first,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  logic [NUM_ENTRIES-1:0] ent_vld, ent_wr;
  logic [BANK_W-1:0]      ent_bank [NUM_ENTRIES];
  logic [ROW_W-1:0]       ent_row  [NUM_ENTRIES];
  logic [COL_W-1:0]       ent_col  [NUM_ENTRIES];
  logic [AGE_W-1:0]       ent_age  [NUM_ENTRIES];
  logic [NUM_BANKS-1:0]   bank_open, bank_rdy;
  logic [ROW_W-1:0]       bank_row [NUM_BANKS];

  logic              pick_vld, pick_from_req, col_rdy_any;
  dcmd_e             pick_cmd;
  logic [BANK_W-1:0] pick_bank;
  logic [ROW_W-1:0]  pick_row;
  logic [COL_W-1:0]  pick_col;
  logic [IDX_W-1:0]  pick_idx;

  // committed command held under back-pressure
  logic              hold_vld, hold_from_req;
  dcmd_e             hold_cmd;
  logic [BANK_W-1:0] hold_bank;
  logic [ROW_W-1:0]  hold_row;
  logic [COL_W-1:0]  hold_col;
  logic [IDX_W-1:0]  hold_idx;

  dcmd_e             sel_cmd;
  logic              sel_from_req, issue, free_en;
  logic [IDX_W-1:0]  sel_idx;

  req_buffer #(
    .NUM_ENTRIES(NUM_ENTRIES), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .COL_W(COL_W), .AGE_W(AGE_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(req_valid), .enq_ready(req_ready),
    .enq_bank(req_bank), .enq_row(req_row), .enq_col(req_col), .enq_wr(req_write),
    .free_en(free_en), .free_idx(sel_idx),
    .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row),
    .ent_col(ent_col), .ent_wr(ent_wr), .ent_age(ent_age)
  );

  cmd_picker #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .AGE_W(AGE_W)
  ) u_pick (
    .cfg_closed_row(cfg_closed_row), .cfg_oldest_first(cfg_oldest_first),
    .ent_vld(ent_vld), .ent_bank(ent_bank), .ent_row(ent_row),
    .ent_col(ent_col), .ent_wr(ent_wr), .ent_age(ent_age),
    .bank_open(bank_open), .bank_row(bank_row), .bank_rdy(bank_rdy),
    .pick_vld(pick_vld), .pick_cmd(pick_cmd), .pick_bank(pick_bank),
    .pick_row(pick_row), .pick_col(pick_col),
    .pick_from_req(pick_from_req), .pick_idx(pick_idx),
    .col_rdy_any(col_rdy_any)
  );

  bank_state #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W),
    .T_RCD(T_RCD), .T_RP(T_RP)
  ) u_banks (
    .clk(clk), .rst_n(rst_n),
    .issue_en(issue), .issue_cmd(sel_cmd), .issue_bank(cmd_bank),
    .issue_row(cmd_row),
    .bank_open(bank_open), .bank_row(bank_row), .bank_rdy(bank_rdy)
  );

  always_comb begin
    if (hold_vld) begin
      sel_cmd      = hold_cmd;
      cmd_bank     = hold_bank;
      cmd_row      = hold_row;
      cmd_col      = hold_col;
      sel_from_req = hold_from_req;
      sel_idx      = hold_idx;
    end else begin
      sel_cmd      = pick_cmd;
      cmd_bank     = pick_bank;
      cmd_row      = pick_row;
      cmd_col      = pick_col;
      sel_from_req = pick_from_req;
      sel_idx      = pick_idx;
    end
  end

  assign cmd_valid = hold_vld || pick_vld;
  assign cmd_type  = sel_cmd;
  assign issue     = cmd_valid && cmd_ready;
  assign free_en   = issue && sel_from_req && cmd_is_col(sel_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld      <= 1'b0;
      hold_from_req <= 1'b0;
      hold_cmd      <= CMD_ACT;
      hold_bank     <= '0;
      hold_row      <= '0;
      hold_col      <= '0;
      hold_idx      <= '0;
    end else if (issue) begin
      hold_vld <= 1'b0;
    end else if (pick_vld && !hold_vld) begin
      hold_vld      <= 1'b1;
      hold_from_req <= pick_from_req;
      hold_cmd      <= pick_cmd;
      hold_bank     <= pick_bank;
      hold_row      <= pick_row;
      hold_col      <= pick_col;
      hold_idx      <= pick_idx;
    end
  end

  // R2: a stalled command is frozen
  a_r2_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_type) && $stable(cmd_bank) &&
       $stable(cmd_row) && $stable(cmd_col)));

  // R4: a fresh row command never passes a ready row hit
  a_r4_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !hold_vld && !cfg_oldest_first && pick_from_req &&
     !cmd_is_col(pick_cmd)) |-> !col_rdy_any);

  // R9: nothing is offered right after reset
  a_r9_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !cmd_valid);
endmodule

// File: tb/dram_row_sched_tb.sv
`timescale 1ns/1ps
module dram_row_sched_tb;
  localparam int T_RCD = 3;
  localparam int T_RP  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_closed_row = 1'b0, cfg_oldest_first = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic       req_ready;
  logic [1:0] req_bank = '0;
  logic [7:0] req_row = '0;
  logic [5:0] req_col = '0;
  logic       cmd_valid, cmd_ready = 1'b1;
  logic [1:0] cmd_type, cmd_bank;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;

  always #5 clk = ~clk;

  dram_row_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_closed_row(cfg_closed_row), .cfg_oldest_first(cfg_oldest_first),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
  );

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int lg_n = 0;
  logic [1:0] lg_t [64];
  logic [1:0] lg_b [64];
  logic [7:0] lg_r [64];
  logic [5:0] lg_c [64];
  int         lg_y [64];

  always @(posedge clk) cyc <= cyc + 1;

  // log each command that the next edge accepts
  always @(negedge clk)
    if (rst_n && cmd_valid && cmd_ready && lg_n < 64) begin
      lg_t[lg_n] = cmd_type; lg_b[lg_n] = cmd_bank;
      lg_r[lg_n] = cmd_row;  lg_c[lg_n] = cmd_col;
      lg_y[lg_n] = cyc;      lg_n = lg_n + 1;
    end

  task automatic check(input logic ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; lg_n = 0;
  endtask

  task automatic enq(input logic [1:0] b, input logic [7:0] r, input logic [5:0] c, input logic w);
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_write = w;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic chk_seq(input string rq, input int n, input logic [15:0] ts, input logic [47:0] cs);
    check(lg_n == n, {rq, " count"}, lg_n, n);
    for (int k = 0; k < n && k < lg_n; k++) begin
      check(lg_t[k] == ts[2*k +: 2], {rq, " type"}, lg_t[k], ts[2*k +: 2]);
      if (ts[2*k+1]) check(lg_c[k] == cs[6*k +: 6], {rq, " col"}, lg_c[k], cs[6*k +: 6]);
    end
  endtask

  // {closed, bank, row, col, write, count, t0, t1, t2}; types 0 ACT 1 PRE 2 RD 3 WR
  localparam logic [25:0] VEC [7] = '{
    {1'b0, 2'd0, 8'd5, 6'd1, 1'b0, 2'd2, 2'd0, 2'd2, 2'd0},
    {1'b0, 2'd0, 8'd5, 6'd2, 1'b1, 2'd1, 2'd3, 2'd0, 2'd0},
    {1'b0, 2'd0, 8'd9, 6'd3, 1'b0, 2'd3, 2'd1, 2'd0, 2'd2},
    {1'b0, 2'd1, 8'd2, 6'd4, 1'b1, 2'd2, 2'd0, 2'd3, 2'd0},
    {1'b1, 2'd2, 8'd7, 6'd0, 1'b0, 2'd3, 2'd0, 2'd2, 2'd1},
    {1'b1, 2'd2, 8'd7, 6'd1, 1'b1, 2'd3, 2'd0, 2'd3, 2'd1},
    {1'b1, 2'd0, 8'd3, 6'd8, 1'b0, 2'd3, 2'd0, 2'd2, 2'd1}
  };

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R9: idle after reset
    @(negedge clk);
    check(cmd_valid == 1'b0, "R9 cmd_valid", cmd_valid, 0);
    check(req_ready == 1'b1, "R9 req_ready", req_ready, 1);

    // vector walk: R3 sequences, R6 closing, R8 gaps
    for (int v = 0; v < 7; v++) begin
      logic [25:0] e;
      logic [1:0]  et;
      int          n;
      e = VEC[v];
      @(posedge clk); #1;
      if (cfg_closed_row != e[25]) begin
        cfg_closed_row = e[25];
        repeat (10) @(posedge clk);
        #1;
      end
      lg_n = 0;
      enq(e[24:23], e[22:15], e[14:9], e[8]);
      repeat (20) @(posedge clk);
      #1;
      n = int'(e[7:6]);
      check(lg_n == n, e[25] ? "R6 count" : "R3 count", lg_n, n);
      for (int k = 0; k < n && k < lg_n; k++) begin
        et = e[5 - 2*k -: 2];
        check(lg_t[k] == et, e[25] ? "R6 type" : "R3 type", lg_t[k], et);
        check(lg_b[k] == e[24:23], "R3 bank", lg_b[k], e[24:23]);
        if (et == 2'd0) check(lg_r[k] == e[22:15], "R3 row", lg_r[k], e[22:15]);
        if (et[1]) check(lg_c[k] == e[14:9], "R3 col", lg_c[k], e[14:9]);
        if (k > 0 && et[1] && lg_t[k-1] == 2'd0)
          check(lg_y[k] - lg_y[k-1] == T_RCD, "R8 act-to-col", lg_y[k] - lg_y[k-1], T_RCD);
        if (k > 0 && et == 2'd0 && lg_t[k-1] == 2'd1)
          check(lg_y[k] - lg_y[k-1] == T_RP, "R8 pre-to-act", lg_y[k] - lg_y[k-1], T_RP);
      end
    end

    // R4 / R5: younger hit passes older conflict
    cfg_closed_row = 1'b0; cfg_oldest_first = 1'b0;
    do_reset();
    enq(2'd0, 8'd1, 6'd0, 1'b0);
    enq(2'd0, 8'd2, 6'd7, 1'b0);
    enq(2'd0, 8'd1, 6'd5, 1'b0);
    repeat (30) @(posedge clk); #1;
    chk_seq("R4", 6, {2'd2, 2'd0, 2'd1, 2'd2, 2'd2, 2'd0},
            {6'd7, 6'd0, 6'd0, 6'd5, 6'd0, 6'd0});

    // R7: same traffic under oldest-first
    cfg_oldest_first = 1'b1;
    do_reset();
    enq(2'd0, 8'd1, 6'd0, 1'b0);
    enq(2'd0, 8'd2, 6'd7, 1'b0);
    enq(2'd0, 8'd1, 6'd5, 1'b0);
    repeat (40) @(posedge clk); #1;
    chk_seq("R7", 8, {2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0},
            {6'd5, 6'd0, 6'd0, 6'd7, 6'd0, 6'd0, 6'd0, 6'd0});
    cfg_oldest_first = 1'b0;

    // R6: buffered hit keeps the row open in closed-row mode
    cfg_closed_row = 1'b1;
    do_reset();
    enq(2'd1, 8'd4, 6'd1, 1'b0);
    enq(2'd1, 8'd4, 6'd2, 1'b0);
    repeat (20) @(posedge clk); #1;
    chk_seq("R6 keep", 4, {2'd1, 2'd2, 2'd2, 2'd0}, {6'd0, 6'd2, 6'd1, 6'd0});
    cfg_closed_row = 1'b0;

    // R2: stalled command stays put
    do_reset();
    cmd_ready = 1'b0;
    enq(2'd3, 8'd6, 6'd9, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(cmd_valid == 1'b1, "R2 valid held", cmd_valid, 1);
      check(cmd_type == 2'd0 && cmd_bank == 2'd3 && cmd_row == 8'd6, "R2 fields held",
            {cmd_type, cmd_bank, cmd_row}, {2'd0, 2'd3, 8'd6});
    end
    @(posedge clk); #1 cmd_ready = 1'b1;
    repeat (20) @(posedge clk); #1;
    chk_seq("R2", 2, {2'd2, 2'd0}, {6'd9, 6'd0});

    // R1 / R5 / R10: full buffer
    do_reset();
    cmd_ready = 1'b0;
    for (int k = 0; k < 8; k++) enq(2'd0, 8'd0, 6'(k), 1'b0);
    @(negedge clk);
    check(req_ready == 1'b0, "R1 full", req_ready, 0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_col = 6'd40;
    repeat (3) @(posedge clk);
    #1 req_valid = 1'b0; cmd_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R10 kept after activate", req_ready, 0);
    repeat (60) @(posedge clk); #1;
    check(lg_n == 9, "R1 dropped request", lg_n, 9);
    check(lg_t[0] == 2'd0, "R1 first is activate", lg_t[0], 0);
    for (int k = 1; k < 9 && k < lg_n; k++)
      check(lg_t[k] == 2'd2 && lg_c[k] == 6'(k - 1), "R5 age order", lg_c[k], k - 1);
    @(negedge clk);
    check(req_ready == 1'b1, "R10 freed", req_ready, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule